// File: doc/BRIEF.md
# Digit-Serial Trinomial Field Multiplier

This block multiplies two elements of the binary field GF(2^89). Each element is held in a polynomial basis, with bit i of a word being the coefficient of x^i. Reduction is modulo the trinomial x^89 + x^38 + 1. The block is a base-field primitive for larger extension-field arithmetic. It trades latency for area: it consumes the second operand four bits per clock, most significant digit first. Each step shifts the running accumulator left by one digit. The bits that overflow past degree 88 are folded back at two fixed taps using shifts and XORs only. The multiplicand times the current digit is then XORed in.

A caller drives both operands and pulses `start`. The operands are captured on that edge. After 23 digit cycles, `done` rises for exactly one cycle and `product` carries the result. The product then holds until the next accepted start. The datapath registers are enabled only while loading or stepping, so an idle multiplier toggles no state.

Top module: `gf89_digit_mult`

## Requirements
- R1: When `start` is sampled high while idle, `opA` and `opB` are captured. The resulting `product` equals opA·opB reduced modulo x^89 + x^38 + 1, with bit i of every word being the coefficient of x^i.
- R2: `done` goes high in the cycle that follows the 23rd rising edge after the capturing edge, and stays high for exactly one cycle.
- R3: A `start` pulse that arrives while a product is in progress is ignored. The running product's result and timing are unchanged.
- R4: Between `done` and the next accepted start, `product` holds its value and does not follow changes on `opA` or `opB`. The datapath state registers are enabled only on a load or a digit step.
- R5: After reset, `done` is low and `product` is zero.
- R6: A zero operand on either side gives a zero product.
- R7: Multiplying by the element 1 (bit 0 only) returns the other operand unchanged, including the all-ones word.
- R8: Overflow past degree 88 is folded back to bits 0 and 38, so x^88 · x gives a product with exactly bits 0 and 38 set.
- R9: A start driven in the same cycle in which `done` is high is accepted, and it yields a correct second product with the same 23-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a product; ignored while busy |
| opA | input | 89 | Multiplicand, polynomial basis |
| opB | input | 89 | Multiplier, consumed 4 bits per cycle from the top |
| product | output | 89 | Reduced product, valid from `done` until the next start |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench uses the default parameters: an 89-bit field, a tap at bit 38 and 4-bit digits. These values give 23 digit steps, and the top digit carries three zero-padding bits. Up to four overflow bits per step are folded back, landing on bits 0..3 and 38..41. With this setting, the x^88 · x case, all-ones operands and a long run of mixed patterns all hit the fold path in every position it can take. A bit-serial reference model checks each result.

// File: rtl/gf89_mult_pkg.sv
package gf89_mult_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;  // capture operands, clear accumulator
    logic step;  // process one multiplier digit
  } mulStrobe_t;

endpackage

// File: rtl/gf89_mult_ctrl.sv
module gf89_mult_ctrl
  import gf89_mult_pkg::*;
#(
  parameter int DIGITS = 23
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mulStrobe_t strb,
  output logic       done
);

  localparam int CNT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             lastStep;

  assign lastStep  = busy && (cnt == CNT_W'(DIGITS - 1));
  assign strb.load = start && !busy;
  assign strb.step = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= lastStep;
      if (strb.load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (lastStep) busy <= 1'b0;
        else          cnt  <= cnt + 1'b1;
      end
    end
  end

  // R2: completion strobe lasts a single cycle
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: done only follows the final digit step
  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rstN)
    lastStep |=> (done && !busy));

  // R3: a start during a busy period does not restart the count
  assert_busy_start_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastStep) |=> (busy && cnt == CNT_W'($past(cnt) + 1'b1)));

  // R2: counter never leaves its range
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DIGITS - 1));

endmodule

// File: rtl/gf89_mult_dp.sv
module gf89_mult_dp
  import gf89_mult_pkg::*;
#(
  parameter int FIELD_W = 89,
  parameter int TAP     = 38,
  parameter int DIGIT_W = 4,
  parameter int DIGITS  = 23
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulStrobe_t         strb,
  input  logic [FIELD_W-1:0] opA,
  input  logic [FIELD_W-1:0] opB,
  output logic [FIELD_W-1:0] acc
);

  localparam int PAD_W = DIGITS * DIGIT_W;   // multiplier padded to whole digits
  localparam int EXT_W = FIELD_W + DIGIT_W;  // width before folding

  logic [FIELD_W-1:0] aReg;
  logic [PAD_W-1:0]   bReg;
  logic [DIGIT_W-1:0] digit;
  logic [EXT_W-1:0]   partial;
  logic [EXT_W-1:0]   wide;
  logic [FIELD_W-1:0] overflow;
  logic [FIELD_W-1:0] accNext;
  logic               regEn;

  assign digit = bReg[PAD_W-1 -: DIGIT_W];
  assign regEn = strb.load || strb.step;

  // Multiplicand times the current digit (carry-less).
  always_comb begin
    partial = '0;
    for (int k = 0; k < DIGIT_W; k++) begin
      if (digit[k]) partial = partial ^ (EXT_W'(aReg) << k);
    end
  end

  // Shift by one digit, add, then fold the top bits: x^FIELD_W == x^TAP + 1.
  // Valid while TAP + DIGIT_W <= FIELD_W, so one fold pass suffices.
  always_comb begin
    wide     = {acc, {DIGIT_W{1'b0}}} ^ partial;
    overflow = FIELD_W'(wide[EXT_W-1:FIELD_W]);
    accNext  = wide[FIELD_W-1:0] ^ overflow ^ (overflow << TAP);
  end

  // State is enabled only on load or step: idle cycles toggle nothing.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
      acc  <= '0;
    end else if (regEn) begin
      if (strb.load) begin
        aReg <= opA;
        bReg <= PAD_W'(opB);
        acc  <= '0;
      end else begin
        bReg <= bReg << DIGIT_W;
        acc  <= accNext;
      end
    end
  end

  // R4: sequencer never asks for load and step together
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.step}));

  // R4: accumulator frozen when neither strobe is active
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !regEn |=> $stable(acc));

  // R1: a load clears the accumulator before the first digit
  assert_load_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (acc == '0));

endmodule

// File: rtl/gf89_digit_mult.sv
module gf89_digit_mult
  import gf89_mult_pkg::*;
#(
  parameter int FIELD_W = 89,
  parameter int TAP     = 38,
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [FIELD_W-1:0] opA,
  input  logic [FIELD_W-1:0] opB,
  output logic [FIELD_W-1:0] product,
  output logic               done
);

  localparam int DIGITS = (FIELD_W + DIGIT_W - 1) / DIGIT_W;

  mulStrobe_t strb;

  gf89_mult_ctrl #(.DIGITS(DIGITS)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  gf89_mult_dp #(
    .FIELD_W (FIELD_W),
    .TAP     (TAP),
    .DIGIT_W (DIGIT_W),
    .DIGITS  (DIGITS)
  ) dp_i (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .opA  (opA),
    .opB  (opB),
    .acc  (product)
  );

  // R4: result holds through the cycle after done unless a new start is taken
  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> $stable(product));

endmodule

// File: tb/gf89_digit_mult_tb_top.sv
module gf89_digit_mult_tb_top;

  localparam int W = 89;
  localparam int LATENCY = 23;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] product;
  logic         done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  gf89_digit_mult dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opA     (opA),
    .opB     (opB),
    .product (product),
    .done    (done)
  );

  // Bit-serial shift-and-add reference, MSB first.
  function automatic logic [W-1:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic top;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      top = r[W-1];
      r = r << 1;
      if (top) begin
        r[0]  = r[0] ^ 1'b1;
        r[38] = r[38] ^ 1'b1;
      end
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam int NVEC = 10;
  localparam logic [2*W-1:0] VEC [NVEC] = '{
    {89'h123456789ABCDEF0123456, 89'h0FEDCBA9876543210FEDCB},
    {ONES,                       ONES},
    {89'h1,                      89'h1},
    {89'h1000000000000000000000, 89'h1000000000000000000000},
    {89'h0AAAAAAAAAAAAAAAAAAAAA, 89'h155555555555555555555},
    {89'h4000000000,             89'h4000000000},
    {89'hDEADBEEFCAFEF00D,       89'h0F0F0F0F0F0F0F0F0F0F0F},
    {ONES,                       89'h3},
    {89'h18000000000000000000000,89'h8000000001},
    {89'h00000000000000000000F1, ONES}
  };

  // Drive start at a negedge, wait for done; returns cycles from capture.
  task automatic runOne(input logic [W-1:0] a, input logic [W-1:0] b, output int n);
    opA = a;
    opB = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    // R5: reset state
    check(done == 1'b0, "R5", "done in reset", W'(done), '0);
    check(product == '0, "R5", "product in reset", product, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && product == '0, "R5", "after reset release", product, '0);

    // R1/R2: vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = VEC[i][2*W-1:W];
      b = VEC[i][W-1:0];
      runOne(a, b, n);
      check(n == LATENCY, "R2", "latency", W'(n), W'(LATENCY));
      check(product == refMul(a, b), "R1", "vector product", product, refMul(a, b));
      @(negedge clk);
      check(done == 1'b0, "R2", "done single cycle", W'(done), '0);
    end

    // R6: zero operands
    runOne('0, 89'h123456789ABCDEF, n);
    check(product == '0, "R6", "zero times b", product, '0);
    runOne(ONES, '0, n);
    check(product == '0, "R6", "a times zero", product, '0);

    // R7: identity
    runOne(ONES, 89'h1, n);
    check(product == ONES, "R7", "ones times one", product, ONES);
    runOne(89'h1, 89'h0ABCDEF0123456789ABCDE, n);
    check(product == 89'h0ABCDEF0123456789ABCDE, "R7", "one times b", product, 89'h0ABCDEF0123456789ABCDE);

    // R8: fold at bits 0 and 38
    runOne(89'h1 << 88, 89'h2, n);
    check(product == ((89'h1 << 38) | 89'h1), "R8", "x^88 * x", product, (89'h1 << 38) | 89'h1);

    // R3: start mid-product is ignored
    opA = 89'h0C0FFEE123456789;
    opB = 89'h1F00D5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    opA = ONES; opB = ONES; start = 1'b1;
    @(negedge clk); n++;
    start = 1'b0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(n == LATENCY, "R3", "latency with stray start", W'(n), W'(LATENCY));
    check(product == refMul(89'h0C0FFEE123456789, 89'h1F00D5), "R3", "stray start product",
          product, refMul(89'h0C0FFEE123456789, 89'h1F00D5));

    // R4: result holds while idle with changing inputs
    held = product;
    for (int k = 0; k < 8; k++) begin
      opA = {W{k[0]}} ^ W'(k * 7919);
      opB = ~opA;
      @(negedge clk);
      check(product == held, "R4", "product hold", product, held);
    end
    check(done == 1'b0, "R4", "no done while idle", W'(done), '0);

    // R9: back-to-back start on the done cycle
    runOne(89'h1B7, 89'h0123456789ABCDEF0, n);
    runOne(89'h0FFFF0000FFFF0000FFFF0, 89'h5A5A5A5A5A, n);
    check(n == LATENCY, "R9", "back-to-back latency", W'(n), W'(LATENCY));
    check(product == refMul(89'h0FFFF0000FFFF0000FFFF0, 89'h5A5A5A5A5A), "R9",
          "back-to-back product", product, refMul(89'h0FFFF0000FFFF0000FFFF0, 89'h5A5A5A5A5A));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule